// File: doc/BRIEF.md
# Serial Console Reset Sequence Detector

This block listens to the received-data line of an asynchronous serial console and raises a system reset when the operator types a short run of control characters. It derives a 16x oversampling tick from the system clock, recovers 8N1 characters with a small UART receiver, and counts how many qualifying characters have arrived back to back. Any character outside the qualifying set, or any corrupted frame, starts the count over.

When the count completes, the block drives a reset pulse of fixed length. Characters that arrive during that pulse are still received and shown on the debug strobe, but they do not count toward a new sequence. With the default divisor of 651 and a 100 MHz clock, the line rate is about 9600 baud. The block has no transmit path and its baud rate cannot be changed at runtime.

Top module: `cr_console_reset`

## Requirements
- R1: While `rst` is high, and in the first cycle after it is released, `sys_reset_o` and `rx_valid_o` are 0. A reset in the middle of a sequence discards the characters already counted.
- R2: The receiver samples the line on a tick that occurs once every CLK_DIV clock cycles, 16 ticks per bit. It decodes 8N1 frames (start bit low, data least-significant bit first, stop bit high). For each good frame it presents the byte on `rx_data_o` together with a `rx_valid_o` strobe that lasts one cycle.
- R3: A low level that has returned high by the start-bit centre, 8 ticks after the falling edge, is treated as noise. It produces no strobe.
- R4: After three back-to-back good frames whose bytes are each 0x18, 0x19 or 0x1A, in any mix, `sys_reset_o` goes high. Bytes that differ from these in any bit, such as 0x98, 0x1B and 0x17, do not qualify.
- R5: `sys_reset_o` stays high for exactly PULSE_CYCLES clock cycles on each trigger.
- R6: A good frame whose byte is not one of the three qualifying values sets the run count back to zero.
- R7: A frame whose stop bit samples low produces no strobe and sets the run count back to zero.
- R8: Characters completed while `sys_reset_o` is high are strobed but ignored by the matcher, and the run count is zero when the pulse ends.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| rx_i | input | 1 | Raw asynchronous serial receive line, idle high |
| sys_reset_o | output | 1 | Registered reset pulse to the system |
| rx_valid_o | output | 1 | Debug strobe, one cycle per good character |
| rx_data_o | output | 8 | Last good character received |

## Verification
A table of frames mixes qualifying and non-qualifying bytes. It includes a run in the order X, Z, Y, runs broken by a printable character, runs broken by a frame with a bad stop bit, and near-miss bytes that differ from a control code by one bit. Together these separate a correct set match from a match on the low bits only, and show that both good and bad frames clear the count. Directed cases follow:
- A short low glitch checks that the start bit is validated at its centre.
- A measured pulse width catches an off-by-one error in the stretcher.
- Characters sent during a long pulse, followed by a single character after it, show whether those characters leaked into the count.
- A reset in the middle of a run checks that the partial count is cleared.

// File: rtl/cr_pkg.sv
package cr_pkg;
  localparam int unsigned CHAR_W = 8;

  typedef enum logic [1:0] {
    RX_IDLE  = 2'd0,
    RX_START = 2'd1,
    RX_DATA  = 2'd2,
    RX_STOP  = 2'd3
  } rx_state_e;

  function automatic logic is_reset_char(input logic [CHAR_W-1:0] b);
    return (b == 8'h18) || (b == 8'h19) || (b == 8'h1A);
  endfunction
endpackage

// File: rtl/cr_tick_gen.sv
module cr_tick_gen #(
  parameter int unsigned DIV = 651
) (
  input  logic clk,
  input  logic rst,
  output logic tick_o
);
  localparam int unsigned W = (DIV > 1) ? $clog2(DIV) : 1;
  localparam logic [W-1:0] LAST = W'(DIV - 1);

  logic [W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt    <= '0;
      tick_o <= 1'b0;
    end else begin
      tick_o <= (cnt == LAST);
      if (cnt == LAST) cnt <= '0;
      else             cnt <= cnt + 1'b1;
    end
  end

  generate
    if (DIV > 1) begin : g_gap_chk
      // R2: ticks are isolated single-cycle pulses
      p_tick_gap_r2: assert property (@(posedge clk) disable iff (rst)
        tick_o |=> !tick_o);
    end
  endgenerate
endmodule

// File: rtl/cr_uart_rx.sv
module cr_uart_rx
  import cr_pkg::*;
#(
  parameter int unsigned OS    = 16,
  parameter int unsigned DBITS = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tick_i,
  input  logic             rx_i,
  output logic             vld_o,
  output logic             err_o,
  output logic [DBITS-1:0] data_o
);
  localparam int unsigned OSW = $clog2(OS);
  localparam int unsigned BW  = (DBITS > 1) ? $clog2(DBITS) : 1;
  localparam logic [OSW-1:0] MID  = OSW'(OS / 2 - 1);
  localparam logic [OSW-1:0] FULL = OSW'(OS - 1);
  localparam logic [BW-1:0]  LASTB = BW'(DBITS - 1);

  logic rx_meta, rx_sync, rx_prev;
  rx_state_e state;
  logic [OSW-1:0] os_cnt;
  logic [BW-1:0]  bit_cnt;
  logic [DBITS-1:0] shreg;

  // two-flop synchroniser plus edge history, idle high
  always_ff @(posedge clk) begin
    if (rst) begin
      rx_meta <= 1'b1;
      rx_sync <= 1'b1;
      rx_prev <= 1'b1;
    end else begin
      rx_meta <= rx_i;
      rx_sync <= rx_meta;
      rx_prev <= rx_sync;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state   <= RX_IDLE;
      os_cnt  <= '0;
      bit_cnt <= '0;
      shreg   <= '0;
      vld_o   <= 1'b0;
      err_o   <= 1'b0;
      data_o  <= '0;
    end else begin
      vld_o <= 1'b0;
      err_o <= 1'b0;
      unique case (state)
        RX_IDLE: begin
          if (rx_prev && !rx_sync) begin
            state  <= RX_START;
            os_cnt <= '0;
          end
        end
        RX_START: begin
          if (tick_i) begin
            if (os_cnt == MID) begin
              os_cnt  <= '0;
              bit_cnt <= '0;
              state   <= rx_sync ? RX_IDLE : RX_DATA;
            end else begin
              os_cnt <= os_cnt + 1'b1;
            end
          end
        end
        RX_DATA: begin
          if (tick_i) begin
            if (os_cnt == FULL) begin
              os_cnt <= '0;
              shreg  <= {rx_sync, shreg[DBITS-1:1]};
              if (bit_cnt == LASTB) state <= RX_STOP;
              else                  bit_cnt <= bit_cnt + 1'b1;
            end else begin
              os_cnt <= os_cnt + 1'b1;
            end
          end
        end
        RX_STOP: begin
          if (tick_i) begin
            if (os_cnt == FULL) begin
              os_cnt <= '0;
              state  <= RX_IDLE;
              if (rx_sync) begin
                vld_o  <= 1'b1;
                data_o <= shreg;
              end else begin
                err_o <= 1'b1;
              end
            end else begin
              os_cnt <= os_cnt + 1'b1;
            end
          end
        end
        default: state <= RX_IDLE;
      endcase
    end
  end

  // R7: a frame ends either good or bad, never both
  p_vld_err_excl_r7: assert property (@(posedge clk) disable iff (rst)
    !(vld_o && err_o));
  // R2: the byte strobe lasts a single cycle
  p_vld_single_r2: assert property (@(posedge clk) disable iff (rst)
    vld_o |=> !vld_o);
  // R3: data phase is entered only if the start bit was low at its centre
  p_start_valid_r3: assert property (@(posedge clk) disable iff (rst)
    (state == RX_DATA && $past(state) == RX_START) |-> !$past(rx_sync));
endmodule

// File: rtl/cr_seq_match.sv
module cr_seq_match
  import cr_pkg::*;
#(
  parameter int unsigned MATCH_LEN    = 3,
  parameter int unsigned PULSE_CYCLES = 1024
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              vld_i,
  input  logic              err_i,
  input  logic [CHAR_W-1:0] data_i,
  output logic              pulse_o
);
  localparam int unsigned CW = (MATCH_LEN > 1) ? $clog2(MATCH_LEN) : 1;
  localparam int unsigned PW = $clog2(PULSE_CYCLES + 1);
  localparam logic [CW-1:0] LASTM = CW'(MATCH_LEN - 1);
  localparam logic [PW-1:0] PLOAD = PW'(PULSE_CYCLES - 1);

  logic [CW-1:0] run_cnt;
  logic [PW-1:0] left;

  always_ff @(posedge clk) begin
    if (rst) begin
      run_cnt <= '0;
      pulse_o <= 1'b0;
      left    <= '0;
    end else if (pulse_o) begin
      run_cnt <= '0;
      if (left == '0) pulse_o <= 1'b0;
      else            left    <= left - 1'b1;
    end else if (err_i) begin
      run_cnt <= '0;
    end else if (vld_i) begin
      if (is_reset_char(data_i)) begin
        if (run_cnt == LASTM) begin
          run_cnt <= '0;
          pulse_o <= 1'b1;
          left    <= PLOAD;
        end else begin
          run_cnt <= run_cnt + 1'b1;
        end
      end else begin
        run_cnt <= '0;
      end
    end
  end

  p_cnt_bound_r4: assert property (@(posedge clk) disable iff (rst)
    run_cnt < CW'(MATCH_LEN));
  p_fire_on_char_r4: assert property (@(posedge clk) disable iff (rst)
    $rose(pulse_o) |-> $past(vld_i));
  p_clear_other_r6: assert property (@(posedge clk) disable iff (rst)
    (vld_i && !pulse_o && !is_reset_char(data_i)) |=> run_cnt == '0);
  p_clear_bad_r7: assert property (@(posedge clk) disable iff (rst)
    err_i |=> run_cnt == '0);
  p_ignore_busy_r8: assert property (@(posedge clk) disable iff (rst)
    pulse_o |=> run_cnt == '0);

  generate
    if (PULSE_CYCLES > 1) begin : g_hold_chk
      p_pulse_hold_r5: assert property (@(posedge clk) disable iff (rst)
        $rose(pulse_o) |=> pulse_o);
    end
  endgenerate
endmodule

// File: rtl/cr_console_reset.sv
module cr_console_reset
  import cr_pkg::*;
#(
  parameter int unsigned CLK_DIV      = 651,
  parameter int unsigned OVERSAMPLE   = 16,
  parameter int unsigned MATCH_LEN    = 3,
  parameter int unsigned PULSE_CYCLES = 1024
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              rx_i,
  output logic              sys_reset_o,
  output logic              rx_valid_o,
  output logic [CHAR_W-1:0] rx_data_o
);
  logic tick;
  logic frame_err;

  cr_tick_gen #(.DIV(CLK_DIV)) u_tick (
    .clk    (clk),
    .rst    (rst),
    .tick_o (tick)
  );

  cr_uart_rx #(.OS(OVERSAMPLE), .DBITS(CHAR_W)) u_rx (
    .clk    (clk),
    .rst    (rst),
    .tick_i (tick),
    .rx_i   (rx_i),
    .vld_o  (rx_valid_o),
    .err_o  (frame_err),
    .data_o (rx_data_o)
  );

  cr_seq_match #(.MATCH_LEN(MATCH_LEN), .PULSE_CYCLES(PULSE_CYCLES)) u_match (
    .clk     (clk),
    .rst     (rst),
    .vld_i   (rx_valid_o),
    .err_i   (frame_err),
    .data_i  (rx_data_o),
    .pulse_o (sys_reset_o)
  );

  // R1: outputs are quiet in the cycle after reset
  p_quiet_after_reset_r1: assert property (@(posedge clk)
    $past(rst) |-> (!sys_reset_o && !rx_valid_o));
endmodule

// File: tb/tb_cr_console_reset.sv
module tb_cr_console_reset;
  localparam int unsigned CLK_DIV = 4;
  localparam int unsigned PULSE   = 1600;
  localparam int unsigned BITC    = CLK_DIV * 16;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic rx  = 1'b1;
  logic sys_reset_o, rx_valid_o;
  logic [7:0] rx_data_o;

  always #10 clk = ~clk;

  cr_console_reset #(.CLK_DIV(CLK_DIV), .PULSE_CYCLES(PULSE)) dut (
    .clk(clk), .rst(rst), .rx_i(rx),
    .sys_reset_o(sys_reset_o), .rx_valid_o(rx_valid_o), .rx_data_o(rx_data_o)
  );

  int checks = 0;
  int errs   = 0;
  int strobes = 0;
  int pulses  = 0;
  int hi_cnt  = 0;
  int last_w  = 0;
  logic [7:0] last_data = 8'h00;
  logic prev_rst_o = 1'b0;

  always @(negedge clk) begin
    if (rx_valid_o) begin
      strobes++;
      last_data = rx_data_o;
    end
    if (sys_reset_o && !prev_rst_o) pulses++;
    if (sys_reset_o) hi_cnt++;
    else if (hi_cnt != 0) begin
      last_w = hi_cnt;
      hi_cnt = 0;
    end
    prev_rst_o = sys_reset_o;
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errs++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic send_frame(input logic [7:0] b, input bit stop_ok);
    @(negedge clk) rx = 1'b0;
    repeat (BITC) @(negedge clk);
    for (int k = 0; k < 8; k++) begin
      rx = b[k];
      repeat (BITC) @(negedge clk);
    end
    rx = stop_ok;
    repeat (BITC) @(negedge clk);
    rx = 1'b1;
    repeat (32) @(negedge clk);
  endtask

  // {byte, stop_ok, expected pulse total, requirement}
  localparam int NVEC = 22;
  localparam logic [16:0] VEC [NVEC] = '{
    {8'h41, 1'b1, 4'd0, 4'd2},
    {8'h18, 1'b1, 4'd0, 4'd4},
    {8'h1A, 1'b1, 4'd0, 4'd4},
    {8'h19, 1'b1, 4'd1, 4'd4},
    {8'h18, 1'b1, 4'd1, 4'd6},
    {8'h19, 1'b1, 4'd1, 4'd6},
    {8'h55, 1'b1, 4'd1, 4'd6},
    {8'h1A, 1'b1, 4'd1, 4'd6},
    {8'h18, 1'b1, 4'd1, 4'd7},
    {8'h00, 1'b0, 4'd1, 4'd7},
    {8'h19, 1'b1, 4'd1, 4'd7},
    {8'h1A, 1'b1, 4'd1, 4'd7},
    {8'h1A, 1'b1, 4'd2, 4'd7},
    {8'h1B, 1'b1, 4'd2, 4'd4},
    {8'h17, 1'b1, 4'd2, 4'd4},
    {8'hA5, 1'b1, 4'd2, 4'd2},
    {8'h18, 1'b1, 4'd2, 4'd4},
    {8'h19, 1'b1, 4'd2, 4'd4},
    {8'h98, 1'b1, 4'd2, 4'd4},
    {8'h1A, 1'b1, 4'd2, 4'd4},
    {8'h1A, 1'b1, 4'd2, 4'd4},
    {8'h18, 1'b1, 4'd3, 4'd4}
  };

  initial begin : watchdog
    repeat (190000) @(posedge clk);
    errs++;
    $display("FAIL watchdog actual=%0h expected=%0h", 1, 0);
    $display("CHECKS %0d ERRORS %0d", checks, errs);
    $finish;
  end

  initial begin : main
    int exp_str;
    repeat (3) @(negedge clk);
    // R1: reset state
    chk(!sys_reset_o && !rx_valid_o, "R1 reset outputs", {sys_reset_o, rx_valid_o}, 0);
    rst = 1'b0;
    repeat (20) @(negedge clk);

    exp_str = 0;
    for (int i = 0; i < NVEC; i++) begin
      send_frame(VEC[i][16:9], VEC[i][8]);
      if (VEC[i][8]) exp_str++;
      chk(strobes == exp_str, $sformatf("R%0d strobe count vec %0d", VEC[i][3:0], i),
          strobes, exp_str);
      if (VEC[i][8])
        chk(last_data == VEC[i][16:9], $sformatf("R2 data vec %0d", i),
            last_data, VEC[i][16:9]);
      chk(pulses == int'(VEC[i][7:4]), $sformatf("R%0d pulses vec %0d", VEC[i][3:0], i),
          pulses, VEC[i][7:4]);
      while (sys_reset_o) @(negedge clk);
    end

    // R5: pulse width
    repeat (2) @(negedge clk);
    chk(last_w == PULSE, "R5 pulse width", last_w, PULSE);

    // R3: short glitch on the line
    @(negedge clk) rx = 1'b0;
    repeat (16) @(negedge clk);
    rx = 1'b1;
    repeat (12 * BITC) @(negedge clk);
    chk(strobes == exp_str, "R3 glitch rejected", strobes, exp_str);

    // R8: characters during the pulse are ignored
    send_frame(8'h18, 1'b1);
    send_frame(8'h19, 1'b1);
    send_frame(8'h1A, 1'b1);
    chk(pulses == 4, "R8 trigger", pulses, 4);
    send_frame(8'h18, 1'b1);
    send_frame(8'h19, 1'b1);
    exp_str += 5;
    chk(sys_reset_o == 1'b1, "R8 pulse still active", sys_reset_o, 1);
    chk(strobes == exp_str, "R8 strobes during pulse", strobes, exp_str);
    while (sys_reset_o) @(negedge clk);
    send_frame(8'h1A, 1'b1);
    exp_str++;
    chk(pulses == 4, "R8 no pulse after busy chars", pulses, 4);
    chk(last_data == 8'h1A, "R8 char received", last_data, 8'h1A);
    send_frame(8'h18, 1'b1);
    send_frame(8'h18, 1'b1);
    chk(pulses == 5, "R8 fresh run fires", pulses, 5);
    while (sys_reset_o) @(negedge clk);

    // R1: reset mid-run discards count
    send_frame(8'h19, 1'b1);
    send_frame(8'h19, 1'b1);
    @(negedge clk) rst = 1'b1;
    repeat (3) @(negedge clk);
    chk(!sys_reset_o && !rx_valid_o, "R1 outputs in reset", {sys_reset_o, rx_valid_o}, 0);
    rst = 1'b0;
    repeat (10) @(negedge clk);
    send_frame(8'h19, 1'b1);
    chk(pulses == 5, "R1 count cleared by reset", pulses, 5);

    $display("CHECKS %0d ERRORS %0d", checks, errs);
    $finish;
  end
endmodule